// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block resolves one virtual address into a page mapping by walking a tree of in-memory tables. A request carries a 32-bit virtual address, the value of a context-table pointer register and a context number. The walker first reads the context entry, then follows pointer entries through up to three directory levels. Each level is indexed by a fixed slice of the virtual address. Every table read goes out on a single-word memory read port whose response can signal a bus error.

A translation ends in one of two ways. It either returns the leaf entry, the level at which it was found and the resulting physical address, or it raises a translation fault. The fault status register records the fault together with the level being fetched when the walk failed. In probe mode the walker returns the raw word reached at a requested level, or zero, and leaves the fault status register alone. Only one walk runs at a time. While `busy` is high, further requests are ignored.

Top module: `pgtw_walker`

## Requirements
- R1: The first memory read of every walk is at address (pointer register << 4) + (context number << 2), computed 36 bits wide.
- R2: A word whose low two bits are 01 is a pointer. The next read is at ((word with bits 1:0 cleared) << 4) plus an offset: VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3. Reads are issued strictly in level order.
- R3: In a translation, a word with low bits 10 fetched at level 1, 2 or 3 ends the walk with `done` high, `done_fault` low, `res_word` equal to that word and `res_level` equal to that level.
- R4: For a leaf found at level 3, 2 or 1, `res_pa` is word[31:8] << 12 with its low 12, 18 or 24 bits replaced by the same bits of the virtual address.
- R5: A bus error on any read during a translation ends the walk at once with `done_fault` high. `fault_status` then holds the level being fetched in bits 9:8, the value 4 in bits 4:2 and zeros elsewhere.
- R6: A translation also faults, with the same encoding and the current level, on type 00 (invalid), on type 11 (reserved), on a pointer fetched at level 3 and on a leaf fetched at level 0 (the context entry).
- R7: In a probe of level T (0 to 3), the walker returns the word fetched at level T, or an earlier leaf word. A bus error, or an invalid or reserved word before level T, gives zero. A probe never raises `done_fault`.
- R8: `fault_status` changes only on a translation fault. Probes and successful translations leave it as it was.
- R9: A request is accepted only when `busy` is low. `busy` stays high until the one-cycle `done` pulse, and requests presented while busy have no effect.
- R10: Once raised, a memory request holds its address unchanged until `mem_req_ready` is seen high.
- R11: After reset, `busy`, `done` and `mem_req_valid` are low and `fault_status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_va | input | 32 | Virtual address to resolve |
| req_ctx_ptr | input | 32 | Context table pointer register value |
| req_ctx | input | 8 | Context number |
| req_probe | input | 1 | 1 = probe, 0 = translation |
| req_probe_lvl | input | 2 | Probe target level |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 36 | Table read address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read ended in a bus error |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_fault | output | 1 | The finished translation faulted |
| res_word | output | 32 | Leaf word or probe result |
| res_pa | output | 36 | Physical address of a successful translation |
| res_level | output | 2 | Level at which the walk ended |
| fault_status | output | 10 | Fault level (9:8) and fault type (4:2) |

## Verification
The bench builds the walker with its default parameters: 32-bit words, an 8-bit context number, an 8/6/6 index split over 4 KB pages, and probe support enabled. These values give all four fetch levels, all four entry types and all three page sizes. The random memory model can place bus errors at any level and can stall the request port, so stalled requests and late responses are also covered. With probe support built in, the same trees can be read back level by level, and a probe can be compared with the translation that preceded it.

// File: rtl/pgtw_pkg.sv
package pgtw_pkg;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_PTR     = 2'd1,
      ET_LEAF    = 2'd2,
      ET_RSVD    = 2'd3
   } etype_t;

   typedef enum logic [2:0] {
      ACT_NEXT,
      ACT_LEAF,
      ACT_FAULT,
      ACT_PROBE_HIT,
      ACT_PROBE_ZERO
   } act_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT
   } state_t;

   localparam logic [2:0] FT_TRANSLATION = 3'd4;
   localparam logic [1:0] LVL_LAST       = 2'd3;

endpackage

// File: rtl/pgtw_addr_gen.sv
module pgtw_addr_gen #(
   parameter int DATA_W    = 32,
   parameter int CTX_W     = 8,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int PAGE_BITS = 12,
   parameter int PA_W      = DATA_W - 8 + PAGE_BITS
) (
   input  logic [1:0]                  lvl,
   input  logic [DATA_W-1:0]           ctx_ptr,
   input  logic [CTX_W-1:0]            ctx,
   input  logic [PA_W-1:0]             base,
   input  logic [DATA_W-PAGE_BITS-1:0] vpn,
   input  logic [DATA_W-3:0]           ptr_field,
   output logic [PA_W-1:0]             fetch_addr,
   output logic [PA_W-1:0]             next_base
);
   localparam int SH    = PA_W - DATA_W;
   localparam int VPN_W = DATA_W - PAGE_BITS;

   logic [L1_BITS-1:0] idx1;
   logic [L2_BITS-1:0] idx2;
   logic [L3_BITS-1:0] idx3;
   logic [PA_W-1:0]    ctx_addr;

   assign idx1 = vpn[VPN_W-1 -: L1_BITS];
   assign idx2 = vpn[L3_BITS+L2_BITS-1 -: L2_BITS];
   assign idx3 = vpn[L3_BITS-1:0];

   assign ctx_addr  = (PA_W'(ctx_ptr) << SH) + (PA_W'(ctx) << 2);
   assign next_base = PA_W'({ptr_field, 2'b00}) << SH;

   always_comb begin
      case (lvl)
         2'd0:    fetch_addr = ctx_addr;
         2'd1:    fetch_addr = base + (PA_W'(idx1) << 2);
         2'd2:    fetch_addr = base + (PA_W'(idx2) << 2);
         default: fetch_addr = base + (PA_W'(idx3) << 2);
      endcase
   end
endmodule

// File: rtl/pgtw_entry_decode.sv
module pgtw_entry_decode
   import pgtw_pkg::*;
#(
   parameter bit PROBE_EN = 1'b1
) (
   input  logic [1:0] etype,
   input  logic       err,
   input  logic [1:0] lvl,
   input  logic       probe,
   input  logic [1:0] plv,
   output act_t       act
);
   logic   probe_eff;
   etype_t t;

   generate
      if (PROBE_EN) begin : g_probe
         assign probe_eff = probe;
      end else begin : g_no_probe
         assign probe_eff = 1'b0;
      end
   endgenerate

   assign t = etype_t'(etype);

   always_comb begin
      if (probe_eff) begin
         if (err)                              act = ACT_PROBE_ZERO;
         else if (lvl == plv)                  act = ACT_PROBE_HIT;
         else if (t == ET_PTR && lvl != LVL_LAST) act = ACT_NEXT;
         else if (t == ET_LEAF)                act = ACT_PROBE_HIT;
         else                                  act = ACT_PROBE_ZERO;
      end else begin
         if (err)                              act = ACT_FAULT;
         else if (t == ET_PTR && lvl != LVL_LAST) act = ACT_NEXT;
         else if (t == ET_LEAF && lvl != 2'd0) act = ACT_LEAF;
         else                                  act = ACT_FAULT;
      end
   end
endmodule

// File: rtl/pgtw_pa_form.sv
module pgtw_pa_form #(
   parameter int DATA_W    = 32,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int PAGE_BITS = 12,
   parameter int PA_W      = DATA_W - 8 + PAGE_BITS
) (
   input  logic [DATA_W-9:0]  ppn,
   input  logic [DATA_W-1:0]  va,
   input  logic [1:0]         lvl,
   output logic [PA_W-1:0]    pa
);
   logic [PA_W-1:0] full;
   logic [PA_W-1:0] cand [1:3];

   assign full = {ppn, {PAGE_BITS{1'b0}}};

   generate
      for (genvar g = 1; g <= 3; g++) begin : g_lvl
         localparam int OFF = PAGE_BITS + ((g < 3) ? L3_BITS : 0) + ((g < 2) ? L2_BITS : 0);
         localparam logic [PA_W-1:0] MASK = (PA_W'(1) << OFF) - PA_W'(1);
         assign cand[g] = (full & ~MASK) | (PA_W'(va) & MASK);
      end
   endgenerate

   always_comb begin
      case (lvl)
         2'd1:    pa = cand[1];
         2'd2:    pa = cand[2];
         2'd3:    pa = cand[3];
         default: pa = full;
      endcase
   end
endmodule

// File: rtl/pgtw_walker.sv
module pgtw_walker
   import pgtw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CTX_W     = 8,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int PAGE_BITS = 12,
   parameter bit PROBE_EN  = 1'b1,
   localparam int PA_W     = DATA_W - 8 + PAGE_BITS,
   localparam int FSR_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_va,
   input  logic [DATA_W-1:0] req_ctx_ptr,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic              req_probe,
   input  logic [1:0]        req_probe_lvl,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              done,
   output logic              done_fault,
   output logic [DATA_W-1:0] res_word,
   output logic [PA_W-1:0]   res_pa,
   output logic [1:0]        res_level,
   output logic [FSR_W-1:0]  fault_status
);
   generate
      if (L1_BITS + L2_BITS + L3_BITS + PAGE_BITS != DATA_W) begin : g_bad_split
         $error("index slices and page offset must cover the word width");
      end
      if (PAGE_BITS < 8) begin : g_bad_page
         $error("page offset must be at least 8 bits");
      end
      if (CTX_W > DATA_W - 2) begin : g_bad_ctx
         $error("context number too wide");
      end
   endgenerate

   state_t            state;
   logic [1:0]        lvl;
   logic [DATA_W-1:0] va_q;
   logic [DATA_W-1:0] ptr_q;
   logic [CTX_W-1:0]  ctx_q;
   logic              probe_q;
   logic [1:0]        plv_q;
   logic [PA_W-1:0]   base_q;
   logic [PA_W-1:0]   next_base;
   logic [PA_W-1:0]   leaf_pa;
   act_t              act;

   assign busy          = (state != ST_IDLE);
   assign mem_req_valid = (state == ST_ISSUE);

   pgtw_addr_gen #(
      .DATA_W(DATA_W), .CTX_W(CTX_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
      .L3_BITS(L3_BITS), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
   ) u_addr (
      .lvl       (lvl),
      .ctx_ptr   (ptr_q),
      .ctx       (ctx_q),
      .base      (base_q),
      .vpn       (va_q[DATA_W-1:PAGE_BITS]),
      .ptr_field (mem_rsp_data[DATA_W-1:2]),
      .fetch_addr(mem_req_addr),
      .next_base (next_base)
   );

   pgtw_entry_decode #(.PROBE_EN(PROBE_EN)) u_dec (
      .etype(mem_rsp_data[1:0]),
      .err  (mem_rsp_err),
      .lvl  (lvl),
      .probe(probe_q),
      .plv  (plv_q),
      .act  (act)
   );

   pgtw_pa_form #(
      .DATA_W(DATA_W), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS),
      .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
   ) u_pa (
      .ppn(mem_rsp_data[DATA_W-1:8]),
      .va (va_q),
      .lvl(lvl),
      .pa (leaf_pa)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         lvl          <= '0;
         va_q         <= '0;
         ptr_q        <= '0;
         ctx_q        <= '0;
         probe_q      <= 1'b0;
         plv_q        <= '0;
         base_q       <= '0;
         done         <= 1'b0;
         done_fault   <= 1'b0;
         res_word     <= '0;
         res_pa       <= '0;
         res_level    <= '0;
         fault_status <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  ptr_q   <= req_ctx_ptr;
                  ctx_q   <= req_ctx;
                  probe_q <= req_probe;
                  plv_q   <= req_probe_lvl;
                  lvl     <= 2'd0;
                  state   <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  case (act)
                     ACT_NEXT: begin
                        base_q <= next_base;
                        lvl    <= lvl + 2'd1;
                        state  <= ST_ISSUE;
                     end
                     ACT_LEAF: begin
                        res_word   <= mem_rsp_data;
                        res_pa     <= leaf_pa;
                        res_level  <= lvl;
                        done_fault <= 1'b0;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                     end
                     ACT_FAULT: begin
                        res_level    <= lvl;
                        done_fault   <= 1'b1;
                        fault_status <= {lvl, 3'b000, FT_TRANSLATION, 2'b00};
                        done         <= 1'b1;
                        state        <= ST_IDLE;
                     end
                     ACT_PROBE_HIT: begin
                        res_word   <= mem_rsp_data;
                        res_level  <= lvl;
                        done_fault <= 1'b0;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                     end
                     default: begin
                        res_word   <= '0;
                        res_level  <= lvl;
                        done_fault <= 1'b0;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                     end
                  endcase
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: a stalled request keeps its address
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R9: no memory traffic while idle
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   // R9: an accepted request starts the walk on the next cycle
   p_start_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (busy && mem_req_valid));

   // R9: completion is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: the fault code carries the type and the level where the walk stopped
   p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (fault_status[4:2] == FT_TRANSLATION &&
                                fault_status[9:8] == res_level));

   // R8: walks that end without a fault leave the status untouched
   p_status_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> $stable(fault_status));

endmodule

// File: tb/pgtw_walker_bench.sv
`timescale 1ns/1ps
module pgtw_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [31:0] req_ctx_ptr = '0;
   logic [7:0]  req_ctx = '0;
   logic        req_probe = 1'b0;
   logic [1:0]  req_probe_lvl = '0;
   logic        busy;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [35:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        done;
   logic        done_fault;
   logic [31:0] res_word;
   logic [35:0] res_pa;
   logic [1:0]  res_level;
   logic [9:0]  fault_status;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   pgtw_walker u_pgtw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_ctx_ptr(req_ctx_ptr), .req_ctx(req_ctx), .req_probe(req_probe),
      .req_probe_lvl(req_probe_lvl), .busy(busy), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_err(mem_rsp_err), .done(done), .done_fault(done_fault),
      .res_word(res_word), .res_pa(res_pa), .res_level(res_level),
      .fault_status(fault_status)
   );

   logic [31:0] mem_d [logic [35:0]];
   bit          mem_e [logic [35:0]];
   logic [35:0] got_fetch [$];
   logic [35:0] e_fetch [$];

   bit          e_fault;
   string       e_tag;
   logic [31:0] e_word;
   logic [35:0] e_pa;
   logic [1:0]  e_level;
   logic [9:0]  exp_fsr = '0;

   logic [31:0] b_va, b_ptr;
   logic [7:0]  b_ctx;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [35:0] a);
      return mem_d.exists(a) ? mem_d[a] : 32'h0;
   endfunction

   function automatic logic [35:0] ctx_addr(input logic [31:0] p, input logic [7:0] c);
      return ({4'h0, p} << 4) + ({28'h0, c} << 2);
   endfunction

   function automatic logic [35:0] next_addr(input logic [31:0] d, input int l,
                                             input logic [31:0] va);
      logic [35:0] base, off;
      base = {d[31:2], 2'b00, 4'h0};
      case (l)
         1:       off = {26'h0, va[31:24], 2'b00};
         2:       off = {28'h0, va[23:18], 2'b00};
         default: off = {28'h0, va[17:12], 2'b00};
      endcase
      return base + off;
   endfunction

   function automatic logic [35:0] leaf_pa(input logic [31:0] d, input int l,
                                           input logic [31:0] va);
      case (l)
         1:       return {d[31:20], va[23:0]};
         2:       return {d[31:14], va[17:0]};
         default: return {d[31:8], va[11:0]};
      endcase
   endfunction

   // memory responder with random stalls; also checks request holding (R10)
   bit          pend = 0;
   bit          stall = 0;
   logic [35:0] paddr, stall_addr;
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; pend = 0; stall = 0;
      end else begin
         mem_rsp_valid = 1'b0;
         if (stall)
            chk("R10", "stalled request", {27'h0, mem_req_valid, mem_req_addr},
                {27'h0, 1'b1, stall_addr});
         stall = 0;
         if (pend) begin
            mem_req_ready = 1'b0;
            if ($urandom % 3 != 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_err   = mem_e.exists(paddr);
               mem_rsp_data  = mem_e.exists(paddr) ? $urandom : rd(paddr);
               pend = 0;
            end
         end else begin
            mem_req_ready = ($urandom % 4 != 0);
            stall = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
               pend = 1;
               paddr = mem_req_addr;
               got_fetch.push_back(mem_req_addr);
            end
         end
      end
   end

   // kind: 1 leaf, 2 bus error, 3 invalid, 4 reserved, 5 pointer; stop_lvl < 0 = random
   task automatic build(input int stop_lvl, input int kind);
      logic [35:0] a;
      logic [31:0] d, r;
      int k, q;
      mem_d.delete(); mem_e.delete();
      b_va = $urandom; b_ptr = $urandom; b_ctx = 8'($urandom);
      a = ctx_addr(b_ptr, b_ctx);
      for (int l = 0; l < 4; l++) begin
         if (stop_lvl < 0) begin
            q = $urandom % 10;
            k = (q < 6) ? 5 : (q < 8) ? 1 : (q == 8) ? 2 : (($urandom % 2) ? 3 : 4);
         end else begin
            k = (l < stop_lvl) ? 5 : kind;
         end
         r = $urandom;
         case (k)
            5: begin
               d = {r[31:2], 2'b01}; mem_d[a] = d;
               if (l == 3) return;
               a = next_addr(d, l + 1, b_va);
            end
            1: begin mem_d[a] = {r[31:2], 2'b10}; return; end
            2: begin mem_e[a] = 1'b1; mem_d[a] = r; return; end
            3: begin mem_d[a] = {r[31:2], 2'b00}; return; end
            default: begin mem_d[a] = {r[31:2], 2'b11}; return; end
         endcase
      end
   endtask

   task automatic ref_walk(input logic [31:0] va, input logic [31:0] ptr,
                           input logic [7:0] ctx, input bit probe, input logic [1:0] plv);
      logic [35:0] a;
      logic [31:0] d;
      e_fetch.delete(); e_fault = 0; e_word = '0; e_pa = '0; e_tag = "R3";
      a = ctx_addr(ptr, ctx);
      for (int l = 0; l < 4; l++) begin
         e_fetch.push_back(a);
         e_level = 2'(l);
         if (mem_e.exists(a)) begin
            if (!probe) begin e_fault = 1; e_tag = "R5"; end
            return;
         end
         d = rd(a);
         if (probe) begin
            if (l == int'(plv)) begin e_word = d; return; end
            if (d[1:0] == 2'b01 && l < 3) begin a = next_addr(d, l + 1, va); continue; end
            e_word = (d[1:0] == 2'b10) ? d : 32'h0;
            return;
         end
         if (d[1:0] == 2'b01 && l < 3) a = next_addr(d, l + 1, va);
         else if (d[1:0] == 2'b10 && l > 0) begin
            e_word = d; e_pa = leaf_pa(d, l, va); return;
         end else begin
            e_fault = 1; e_tag = "R6"; return;
         end
      end
   endtask

   task automatic do_walk(input bit probe, input logic [1:0] plv, input bit stray);
      bit got;
      ref_walk(b_va, b_ptr, b_ctx, probe, plv);
      got_fetch.delete();
      @(negedge clk);
      req_valid = 1'b1; req_va = b_va; req_ctx_ptr = b_ptr; req_ctx = b_ctx;
      req_probe = probe; req_probe_lvl = plv;
      @(negedge clk);
      chk("R9", "busy after accept", {63'h0, busy}, 64'h1);
      if (stray) begin
         req_va = ~b_va; req_ctx = ~b_ctx; req_probe = ~probe;
      end else req_valid = 1'b0;
      got = 0;
      for (int c = 0; c < 400 && !got; c++) begin
         if (done) got = 1;
         else begin
            @(negedge clk);
            if (c == 0) req_valid = 1'b0;
         end
      end
      if (!got) begin
         chk("R9", "walk never finished", 64'h0, 64'h1);
         return;
      end
      chk("R2", "fetch count", 64'(got_fetch.size()), 64'(e_fetch.size()));
      for (int i = 0; i < e_fetch.size() && i < got_fetch.size(); i++)
         chk((i == 0) ? "R1" : "R2", "fetch address", {28'h0, got_fetch[i]}, {28'h0, e_fetch[i]});
      if (probe) begin
         chk("R7", "probe fault flag", {63'h0, done_fault}, 64'h0);
         chk("R7", "probe word", {32'h0, res_word}, {32'h0, e_word});
         chk("R8", "status after probe", {54'h0, fault_status}, {54'h0, exp_fsr});
      end else if (e_fault) begin
         exp_fsr = {e_level, 3'b000, 3'b100, 2'b00};
         chk(e_tag, "fault flag", {63'h0, done_fault}, 64'h1);
         chk(e_tag, "fault status", {54'h0, fault_status}, {54'h0, exp_fsr});
         chk(e_tag, "fault level", {62'h0, res_level}, {62'h0, e_level});
      end else begin
         chk("R3", "fault flag", {63'h0, done_fault}, 64'h0);
         chk("R3", "leaf word", {32'h0, res_word}, {32'h0, e_word});
         chk("R3", "leaf level", {62'h0, res_level}, {62'h0, e_level});
         chk("R4", "physical address", {28'h0, res_pa}, {28'h0, e_pa});
         chk("R8", "status after success", {54'h0, fault_status}, {54'h0, exp_fsr});
      end
   endtask

   initial begin
      #(20 * 200000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "busy", {63'h0, busy}, 64'h0);
      chk("R11", "done", {63'h0, done}, 64'h0);
      chk("R11", "mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
      chk("R11", "fault_status", {54'h0, fault_status}, 64'h0);

      // leaves at each level: R3, R4
      for (int l = 3; l >= 1; l--) begin build(l, 1); do_walk(0, 2'd0, 0); end
      // bus error at each level: R5
      for (int l = 0; l < 4; l++) begin build(l, 2); do_walk(0, 2'd0, 0); end
      // structural faults: R6
      build(0, 1); do_walk(0, 2'd0, 0);
      build(1, 3); do_walk(0, 2'd0, 0);
      build(2, 4); do_walk(0, 2'd0, 0);
      build(3, 5); do_walk(0, 2'd0, 0);
      // probes on one tree at every level: R7, R8
      build(3, 1);
      for (int p = 0; p < 4; p++) do_walk(1, 2'(p), 0);
      build(2, 2); do_walk(1, 2'd3, 0);
      build(1, 3); do_walk(1, 2'd2, 0);
      build(1, 1); do_walk(1, 2'd3, 0);
      // requests while busy are ignored: R9
      build(3, 1); do_walk(0, 2'd0, 1);
      build(2, 2); do_walk(0, 2'd0, 1);

      for (int n = 0; n < 300; n++) begin
         build(-1, 0);
         do_walk(($urandom % 4) == 0, 2'($urandom), ($urandom % 8) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule